// File: doc/BRIEF.md
# Asynchronous Memory Wait-State Sequencer

This block runs one access, single or burst, to an asynchronous SRAM, ROM, Flash or I/O device. It drives a read or write strobe and holds it for a programmable number of wait cycles. After that count has run out, a low ready input can keep the strobe asserted for longer. Devices with a page mode are handled with two wait settings. A longer wait opens each page. A shorter wait serves the following beats that stay inside the same page. A burst that crosses into a new page pays the opening wait again.

A start pulse loads the timing configuration, the direction, the burst length and the starting word offset within the page. Between beats the block pulses an address-increment output. On reads it flags the cycle in which data must be captured. After the last beat it inserts a programmable number of recovery cycles, then signals completion. While an access is in progress, start requests are dropped.

Top module: `amws_seq`

## Requirements
- R1: After reset, and whenever busy_o is low, rd_o, wr_o, capture_o, addr_inc_o and done_o are all low.
- R2: A start_i seen while idle makes busy_o high on the next cycle. Exactly one setup cycle, with no strobe, precedes the first beat.
- R3: A beat asserts rd_o (write_i=0) or wr_o (write_i=1), never both. With rdy_i high, the strobe lasts the applicable wait count plus one cycle, for wait counts 0 to 15.
- R4: rdy_i is looked at only once the wait count has expired. While it is low after that point, the strobe stays asserted. A low rdy_i during the counted wait has no effect.
- R5: With page_en_i=1, the first beat uses first_wait_i. A later beat in the same page uses page_wait_i and follows the previous beat after a single idle cycle, with no setup.
- R6: page_sel_i picks the page size: 0 gives 2 words, 1 gives 4 words, 2 or 3 gives 8 words. The word offset starts at start_off_i and increases by one per beat. A beat at offset 0 of a new page gets a setup cycle and first_wait_i.
- R7: burst_sel_i values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. addr_inc_o pulses once between consecutive beats, with no strobe. On reads, capture_o pulses once per beat, in the last strobe cycle. On writes it stays low.
- R8: After the last beat there is one idle cycle, then recover_i+1 recovery cycles. done_o pulses once, in the final recovery cycle. busy_o is low on the cycle after.
- R9: A start_i that arrives while busy_o is high does not change the running access and is not queued. Configuration inputs are captured only when an access is accepted.
- R10: With page_en_i=0, every beat gets a setup cycle and first_wait_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request pulse |
| write_i | input | 1 | 1 = write, 0 = read |
| burst_sel_i | input | 2 | Beat count select (1,2,4,8) |
| page_en_i | input | 1 | Device uses page timing |
| page_sel_i | input | 2 | Page size select (2,4,8,8) |
| start_off_i | input | OFF_W | Word offset of first beat within page |
| first_wait_i | input | WAIT_W | Wait count for a page-opening beat |
| page_wait_i | input | WAIT_W | Wait count for an in-page beat |
| recover_i | input | REC_W | Recovery cycles minus one |
| rdy_i | input | 1 | Device ready, stretches strobe when low |
| busy_o | output | 1 | Access in progress |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| capture_o | output | 1 | Read data valid this cycle |
| addr_inc_o | output | 1 | Advance address to next word |
| done_o | output | 1 | Access complete pulse |

## Verification
A wrong wait counter shows up at once at the ports as a strobe whose length is off by a cycle or more. A wrong ready decision shows up as a strobe cut short or a hung access. Page tracking errors appear in the next beat. The gap after the previous strobe then grows from one to two cycles, or shrinks from two to one, and the strobe length switches between the two wait settings. A wrong beat or recovery count changes the number of address increments, the number of captures or the distance to done, all within that same access.

// File: rtl/amws_pkg.sv
package amws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_END,
    ST_RECOVER
  } amws_state_e;

  localparam int unsigned BSEL_W = 2;
  localparam int unsigned PSEL_W = 2;

  // mask of the in-page word offset bits
  function automatic logic [7:0] page_mask(input logic [PSEL_W-1:0] sel);
    logic [7:0] m;
    case (sel)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      default: m = 8'h07;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] beats_minus_one(input logic [BSEL_W-1:0] sel);
    return (8'd1 << sel) - 8'd1;
  endfunction
endpackage

// File: rtl/amws_dn_cnt.sv
module amws_dn_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/amws_beat_trk.sv
module amws_beat_trk
  import amws_pkg::*;
#(
  parameter int unsigned OFF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BSEL_W-1:0] burst_sel_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              adv_i,
  output logic              last_o,
  output logic              cross_o
);
  logic [OFF_W-1:0]  left_q;
  logic [OFF_W-1:0]  off_q;
  logic [PSEL_W-1:0] psel_q;
  logic [OFF_W-1:0]  mask;
  logic [7:0]        mask_full;
  logic [7:0]        left_full;

  assign mask_full = page_mask(psel_q);
  assign mask      = mask_full[OFF_W-1:0];
  assign left_full = beats_minus_one(burst_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      off_q  <= '0;
      psel_q <= '0;
    end else if (load_i) begin
      left_q <= left_full[OFF_W-1:0];
      off_q  <= off_i;
      psel_q <= page_sel_i;
    end else if (adv_i) begin
      left_q <= left_q - 1'b1;
      off_q  <= off_q + 1'b1;
    end
  end

  assign last_o  = (left_q == '0);
  // current beat sits on the last word of its page
  assign cross_o = ((off_q & mask) == mask);
endmodule

// File: rtl/amws_seq.sv
module amws_seq
  import amws_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned REC_W  = 4,
  parameter int unsigned OFF_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [BSEL_W-1:0] burst_sel_i,
  input  logic              page_en_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic [WAIT_W-1:0] first_wait_i,
  input  logic [WAIT_W-1:0] page_wait_i,
  input  logic [REC_W-1:0]  recover_i,
  input  logic              rdy_i,
  output logic              busy_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              capture_o,
  output logic              addr_inc_o,
  output logic              done_o
);
  amws_state_e state_q, state_d;

  logic              wr_q, pen_q;
  logic [WAIT_W-1:0] fw_q, pw_q;
  logic [REC_W-1:0]  rec_q;

  logic              accept;
  logic              wait_load, wait_zero, wait_dec;
  logic [WAIT_W-1:0] wait_val;
  logic              rec_load, rec_zero, rec_dec;
  logic              beat_last, beat_cross, beat_adv;
  logic              beat_done, next_in_page;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      pen_q <= 1'b0;
      fw_q  <= '0;
      pw_q  <= '0;
      rec_q <= '0;
    end else if (accept) begin
      wr_q  <= write_i;
      pen_q <= page_en_i;
      fw_q  <= first_wait_i;
      pw_q  <= page_wait_i;
      rec_q <= recover_i;
    end
  end

  amws_beat_trk #(.OFF_W(OFF_W)) u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .burst_sel_i(burst_sel_i),
    .page_sel_i (page_sel_i),
    .off_i      (start_off_i),
    .adv_i      (beat_adv),
    .last_o     (beat_last),
    .cross_o    (beat_cross)
  );

  amws_dn_cnt #(.W(WAIT_W)) u_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wait_load),
    .val_i (wait_val),
    .dec_i (wait_dec),
    .zero_o(wait_zero)
  );

  amws_dn_cnt #(.W(REC_W)) u_rec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rec_load),
    .val_i (rec_q),
    .dec_i (rec_dec),
    .zero_o(rec_zero)
  );

  // ready only matters once the programmed wait has run out
  assign beat_done    = (state_q == ST_WAIT) && wait_zero && rdy_i;
  assign next_in_page = pen_q && !beat_cross;

  always_comb begin
    state_d   = state_q;
    wait_load = 1'b0;
    wait_val  = fw_q;
    wait_dec  = 1'b0;
    rec_load  = 1'b0;
    rec_dec   = 1'b0;
    beat_adv  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SETUP;
      ST_SETUP: begin
        wait_load = 1'b1;
        wait_val  = fw_q;
        state_d   = ST_WAIT;
      end
      ST_WAIT: begin
        wait_dec = 1'b1;
        if (beat_done) state_d = ST_END;
      end
      ST_END: begin
        if (beat_last) begin
          rec_load = 1'b1;
          state_d  = ST_RECOVER;
        end else begin
          beat_adv = 1'b1;
          if (next_in_page) begin
            wait_load = 1'b1;
            wait_val  = pw_q;
            state_d   = ST_WAIT;
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_RECOVER: begin
        rec_dec = 1'b1;
        if (rec_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign rd_o       = (state_q == ST_WAIT) && !wr_q;
  assign wr_o       = (state_q == ST_WAIT) && wr_q;
  assign capture_o  = beat_done && !wr_q;
  assign addr_inc_o = beat_adv;
  assign done_o     = (state_q == ST_RECOVER) && rec_zero;
endmodule

// File: rtl/amws_chk.sv
module amws_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rdy_i,
  input logic busy_o,
  input logic rd_o,
  input logic wr_o,
  input logic capture_o,
  input logic addr_inc_o,
  input logic done_o
);
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(rd_o || wr_o || capture_o || addr_inc_o || done_o));

  a_r2_accept_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !rd_o && !wr_o));

  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  a_r4_hold_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && !rdy_i) |=> (rd_o || wr_o));

  a_r7_capture_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> rd_o);

  a_r7_capture_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !rd_o);

  a_r7_inc_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_inc_o |-> !(rd_o || wr_o));

  a_r8_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind amws_seq amws_chk u_amws_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rdy_i     (rdy_i),
  .busy_o    (busy_o),
  .rd_o      (rd_o),
  .wr_o      (wr_o),
  .capture_o (capture_o),
  .addr_inc_o(addr_inc_o),
  .done_o    (done_o)
);

// File: tb/tb_amws_seq.sv
module tb_amws_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       write_i = 1'b0;
  logic [1:0] burst_sel_i = '0;
  logic       page_en_i = 1'b0;
  logic [1:0] page_sel_i = '0;
  logic [2:0] start_off_i = '0;
  logic [3:0] first_wait_i = '0;
  logic [3:0] page_wait_i = '0;
  logic [3:0] recover_i = '0;
  logic       rdy_i = 1'b1;
  logic       busy_o, rd_o, wr_o, capture_o, addr_inc_o, done_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  amws_seq dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .write_i     (write_i),
    .burst_sel_i (burst_sel_i),
    .page_en_i   (page_en_i),
    .page_sel_i  (page_sel_i),
    .start_off_i (start_off_i),
    .first_wait_i(first_wait_i),
    .page_wait_i (page_wait_i),
    .recover_i   (recover_i),
    .rdy_i       (rdy_i),
    .busy_o      (busy_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .capture_o   (capture_o),
    .addr_inc_o  (addr_inc_o),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one access, measured at the ports and compared with a model of the rules
  task automatic run_case(input string tag, input bit wr, input int bsel,
                          input int pen, input int psel, input int off,
                          input int fw, input int pw, input int rec,
                          input int stall, input bit inject);
    int lens[8];
    int gaps[8];
    int beat = 0, cur = 0, gap = 0, busy_n = 0, incs = 0, caps = 0;
    int dones = 0, pol_bad = 0, cap_bad = 0, c0 = 0, cyc = 0;
    int n, mask, exp_busy, w, el, eg;
    bit prev_st = 0, prev_cap = 0, fin = 0, st, newp;
    for (int i = 0; i < 8; i++) begin lens[i] = 0; gaps[i] = 0; end

    @(negedge clk_i);
    write_i = wr; burst_sel_i = bsel[1:0]; page_en_i = pen[0];
    page_sel_i = psel[1:0]; start_off_i = off[2:0];
    first_wait_i = fw[3:0]; page_wait_i = pw[3:0]; recover_i = rec[3:0];
    start_i = 1'b1;
    while (!fin && cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
      start_i = 1'b0;
      if (inject && cyc == 3) begin
        start_i = 1'b1; first_wait_i = 4'd15; write_i = !wr; burst_sel_i = 2'd3;
      end
      st = rd_o | wr_o;
      if (st && beat == 0) c0++;
      rdy_i = !(st && beat == 0 && c0 <= stall);
      #1;
      if (busy_o) busy_n++;
      if (prev_cap && rd_o) cap_bad++;
      if ((wr && rd_o) || (!wr && wr_o)) pol_bad++;
      if (st) begin
        if (!prev_st && beat < 8) begin gaps[beat] = gap; gap = 0; end
        cur++;
      end else begin
        if (prev_st) begin
          if (beat < 8) lens[beat] = cur;
          cur = 0; beat++;
        end
        if (busy_o) gap++;
      end
      if (addr_inc_o) incs++;
      if (capture_o) caps++;
      if (capture_o && !rd_o) cap_bad++;
      if (done_o) begin dones++; fin = 1; end
      prev_st = st;
      prev_cap = capture_o;
    end
    rdy_i = 1'b1;
    write_i = wr; first_wait_i = fw[3:0]; burst_sel_i = bsel[1:0];

    n = 1 << bsel;
    mask = (psel == 0) ? 1 : (psel == 1) ? 3 : 7;
    exp_busy = rec + 2;
    chk(fin, "R8", {tag, " done reached"}, fin, 1);
    chk(beat == n, "R7", {tag, " beat count"}, beat, n);
    for (int k = 0; k < n && k < 8; k++) begin
      newp = (k == 0) || (pen == 0) || (((off + k) & mask) == 0);
      w = newp ? fw : pw;
      el = w + 1;
      if (k == 0 && stall >= el) el = stall + 1;
      eg = (k == 0) ? 1 : (newp ? 2 : 1);
      exp_busy += el + eg;
      chk(lens[k] == el, tag, $sformatf("beat %0d strobe length", k), lens[k], el);
      chk(gaps[k] == eg, (pen != 0) ? "R6" : "R10",
          $sformatf("%s beat %0d lead gap", tag, k), gaps[k], eg);
    end
    chk(gap == rec + 2, "R8", {tag, " tail cycles"}, gap, rec + 2);
    chk(busy_n == exp_busy, "R2", {tag, " busy cycles"}, busy_n, exp_busy);
    chk(incs == n - 1, "R7", {tag, " addr increments"}, incs, n - 1);
    chk(caps == (wr ? 0 : n), "R7", {tag, " captures"}, caps, wr ? 0 : n);
    chk(cap_bad == 0, "R7", {tag, " capture placement"}, cap_bad, 0);
    chk(dones == 1, "R8", {tag, " done pulses"}, dones, 1);
    chk(pol_bad == 0, "R3", {tag, " strobe polarity"}, pol_bad, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_i); #1;
      chk(!busy_o && !rd_o && !wr_o, "R9", {tag, " idle after done"}, busy_o, 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk({busy_o, rd_o, wr_o, capture_o, addr_inc_o, done_o} == 6'b0, "R1",
        "outputs in reset", {busy_o, rd_o, wr_o, capture_o, addr_inc_o, done_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk({busy_o, rd_o, wr_o, capture_o, addr_inc_o, done_o} == 6'b0, "R1",
        "outputs after reset", {busy_o, rd_o, wr_o, capture_o, addr_inc_o, done_o}, 0);
  endtask

  task automatic t_single_read;   run_case("R3", 0, 0, 0, 0, 0, 3, 0, 1, 0, 0);  endtask
  task automatic t_single_write;  run_case("R3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);  endtask
  task automatic t_max_wait;      run_case("R3", 0, 0, 0, 0, 0, 15, 0, 0, 0, 0); endtask
  task automatic t_ready_stretch; run_case("R4", 0, 0, 0, 0, 0, 2, 0, 0, 7, 0);  endtask
  task automatic t_ready_early;   run_case("R4", 1, 0, 0, 0, 0, 5, 0, 0, 3, 0);  endtask
  task automatic t_page_burst;    run_case("R5", 0, 2, 1, 1, 0, 4, 1, 2, 0, 0);  endtask
  task automatic t_page_cross2;   run_case("R6", 0, 3, 1, 0, 1, 3, 0, 0, 0, 0);  endtask
  task automatic t_page_cross8;   run_case("R6", 1, 2, 1, 2, 5, 2, 1, 1, 0, 0);  endtask
  task automatic t_page_stall;    run_case("R6", 0, 1, 1, 3, 6, 1, 3, 0, 5, 0);  endtask
  task automatic t_no_page;       run_case("R10", 0, 1, 0, 2, 0, 2, 0, 0, 0, 0); endtask
  task automatic t_long_recover;  run_case("R8", 1, 0, 0, 0, 0, 1, 0, 15, 0, 0); endtask
  task automatic t_ignore_start;  run_case("R9", 0, 1, 1, 1, 0, 3, 1, 2, 0, 1);  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_read();
    t_single_write();
    t_max_wait();
    t_ready_stretch();
    t_ready_early();
    t_page_burst();
    t_page_cross2();
    t_page_cross8();
    t_page_stall();
    t_no_page();
    t_long_recover();
    t_ignore_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule